// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero-Turnaround Bus

This block is a synthesizable model of a small synchronous static RAM whose data bus can carry any mix of reads and writes on consecutive clocks with no idle cycle between them. Address, control and byte-write enables are taken at the rising clock edge. Write data trails its address by a fixed lag, so the bus slot that a write's data uses lines up with the slot a read would use. A read therefore never has to wait for the bus to turn around.

A static mode input picks between two latencies. In registered-output mode, read data leaves through an output register one edge later. Write data then lags its address by two cycles. In pass-through mode, read data appears within the access cycle and write data lags by one cycle. Three chip selects qualify every new cycle. An advance input continues a four-beat burst in linear or interleaved order. An output-enable input and a sleep input act asynchronously on the output drivers. A read that hits a write whose data is on the bus in that same cycle returns the merged bytes.

Top module: `lw_sram`

## Requirements
- R1: A new cycle starts only when `sel0`, `sel1` and `sel2` are all high, `adv` is low and `sleep` is low at the rising edge. Otherwise the edge is a deselect, and no read data is driven for it later.
- R2: With `pipe_mode` low, read data for a command taken at edge k is valid on `q`, with `q_oe` high, after edge k and before edge k+1.
- R3: With `pipe_mode` high, read data for a command taken at edge k is valid on `q`, with `q_oe` high, after edge k+1 and before edge k+2.
- R4: Write data for a write taken at edge k is taken from `din` at edge k+1 when `pipe_mode` is low, and at edge k+2 when it is high.
- R5: Writes are byte-granular. Bit i of `bwe`, taken with the address, enables byte i (`din` bits 9i+8 down to 9i). A byte whose enable is low keeps its old contents.
- R6: Reads and writes to any addresses may follow each other on every clock. Each read returns the newest data, including a read issued the cycle after a write to the same word in registered mode, whose bytes are merged from `din`.
- R7: With `adv` high while a burst is active, the cycle repeats the burst's direction and ignores the selects, `we` and `addr`. With `burst_ilv` low, the two low address bits step +1 modulo 4 from the start address and the upper bits stay fixed.
- R8: With `burst_ilv` high, a continued burst uses low address bits equal to the start low bits XOR a beat count of 1, 2, 3, 0, and so on.
- R9: `adv` high with no burst active (after a deselect, sleep or reset) is a deselect.
- R10: `oe_n` high forces `q_oe` low in the same cycle, whatever the pipeline holds.
- R11: While `sleep` is high, `q_oe` is low, no new cycle is taken and any burst ends.
- R12: After reset, `q_oe` is low and no read or write is pending.
- R13: `q_oe` is high only in the cycles where read data is due, so deselect and write cycles leave the bus undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline |
| pipe_mode | input | 1 | Static: 1 registered output, 0 pass-through |
| burst_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sel0 | input | 1 | Chip select, active high |
| sel1 | input | 1 | Chip select, active high |
| sel2 | input | 1 | Chip select, active high |
| adv | input | 1 | Continue the current burst |
| we | input | 1 | 1 write, 0 read |
| bwe | input | NB | Per-byte write enables |
| addr | input | AW | Word address |
| din | input | NB*BW | Late write data |
| oe_n | input | 1 | Asynchronous output disable, active high |
| sleep | input | 1 | Asynchronous power-down request |
| q | output | NB*BW | Read data |
| q_oe | output | 1 | Output driver enable for `q` |

## Verification
Random streams mix reads, writes, burst continuations, partial selects, sleep and output disable. These streams run in both latency modes and both burst orders. A reference memory is updated at the edge where each write's late data is taken, and reads are compared in the slot the mode predicts. This separates off-by-one latency faults from wrong forwarding. Directed cases pin down individual effects. Back-to-back write/read pairs to one word, with full and partial byte enables, expose missing or whole-word forwarding. Burst start addresses with nonzero low bits show the difference between linear wrap and XOR order. An advance after a deselect, a read under sleep and a read slot with output disabled each show whether a gate is missing.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Number of low address bits stepped by a burst (four beats).
    localparam int BEAT_W = 2;

    // Low address bits for a given beat of a burst.
    function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] start,
                                                  input logic [BEAT_W-1:0] beat,
                                                  input logic              ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lw_sram_seq.sv
module lw_sram_seq
    import lw_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          adv,
    input  logic          sel,
    input  logic          we,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output logic          cmd_vld,
    output logic          cmd_wr,
    output logic          cont,
    output logic [AW-1:0] cmd_addr
);

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [AW-1:0]     base;
        logic [BEAT_W-1:0] cnt;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        cmd_vld  = 1'b0;
        cmd_wr   = st_q.wr;
        cmd_addr = st_q.base;
        cont     = 1'b0;
        if (sleep) begin
            st_d.act = 1'b0;
        end else if (adv) begin
            if (st_q.act) begin
                st_d.cnt = st_q.cnt + 1'b1;
                cont     = 1'b1;
                cmd_vld  = 1'b1;
                cmd_wr   = st_q.wr;
                cmd_addr = {st_q.base[AW-1:BEAT_W],
                            beat_lo(st_q.base[BEAT_W-1:0], st_d.cnt, ilv)};
            end
        end else if (sel) begin
            st_d.act  = 1'b1;
            st_d.wr   = we;
            st_d.base = addr;
            st_d.cnt  = '0;
            cmd_vld   = 1'b1;
            cmd_wr    = we;
            cmd_addr  = addr;
        end else begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a continued beat keeps the direction of the beat before it
    a_r7_burst_same_dir: assert property (@(posedge clk) disable iff (!rst_n)
        cont |-> (cmd_wr == $past(cmd_wr)));

endmodule

// File: rtl/lw_sram_mem.sv
module lw_sram_mem #(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             wen,
    input  logic [AW-1:0]    waddr,
    input  logic [NB-1:0]    wbe,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wen && wbe[b]) lane_q[waddr] <= wdata[b*BW +: BW];
        end

        assign rdata[b*BW +: BW] = lane_q[raddr];
    end

endmodule

// File: rtl/lw_sram_fwd.sv
module lw_sram_fwd #(
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic [NB*BW-1:0] mem_data,
    input  logic             hit,
    input  logic [NB-1:0]    be,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rd_data
);

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign rd_data[b*BW +: BW] = (hit && be[b]) ? wdata[b*BW +: BW]
                                                     : mem_data[b*BW +: BW];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_mode,
    input  logic             burst_ilv,
    input  logic             sel0,
    input  logic             sel1,
    input  logic             sel2,
    input  logic             adv,
    input  logic             we,
    input  logic [NB-1:0]    bwe,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] din,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [NB*BW-1:0] q,
    output logic             q_oe
);

    localparam int DW = NB * BW;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } cmd_t;

    typedef struct packed {
        cmd_t          s1;
        cmd_t          s2;
        logic [DW-1:0] odat;
        logic          ovld;
    } top_t;

    top_t st_q, st_d;

    logic          cmd_vld, cmd_wr, cont;
    logic [AW-1:0] cmd_addr;
    logic          wen;
    logic [AW-1:0] waddr;
    logic [NB-1:0] wbe;
    logic [DW-1:0] mem_rd, merged;
    logic          hit, rd_now, rd_vld;

    lw_sram_seq #(.AW(AW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .adv      (adv),
        .sel      (sel0 && sel1 && sel2),
        .we       (we),
        .ilv      (burst_ilv),
        .addr     (addr),
        .cmd_vld  (cmd_vld),
        .cmd_wr   (cmd_wr),
        .cont     (cont),
        .cmd_addr (cmd_addr)
    );

    lw_sram_mem #(.AW(AW), .NB(NB), .BW(BW)) mem_i (
        .clk   (clk),
        .wen   (wen),
        .waddr (waddr),
        .wbe   (wbe),
        .wdata (din),
        .raddr (st_q.s1.addr),
        .rdata (mem_rd)
    );

    lw_sram_fwd #(.NB(NB), .BW(BW)) fwd_i (
        .mem_data (mem_rd),
        .hit      (hit),
        .be       (st_q.s2.be),
        .wdata    (din),
        .rd_data  (merged)
    );

    always_comb begin
        st_d = st_q;

        // Stage 1: command taken at this edge
        st_d.s1.vld  = cmd_vld;
        st_d.s1.wr   = cmd_wr;
        st_d.s1.addr = cmd_addr;
        st_d.s1.be   = bwe;

        // Stage 2 exists only for the two-cycle write lag
        st_d.s2 = pipe_mode ? st_q.s1 : '0;

        // Write commit: the stage whose data is on din now
        if (pipe_mode) begin
            wen   = st_q.s2.vld && st_q.s2.wr;
            waddr = st_q.s2.addr;
            wbe   = st_q.s2.be;
        end else begin
            wen   = st_q.s1.vld && st_q.s1.wr;
            waddr = st_q.s1.addr;
            wbe   = st_q.s1.be;
        end

        rd_now = st_q.s1.vld && !st_q.s1.wr;
        hit    = pipe_mode && rd_now && st_q.s2.vld && st_q.s2.wr
                 && (st_q.s2.addr == st_q.s1.addr);

        st_d.odat = merged;
        st_d.ovld = pipe_mode && rd_now;

        rd_vld = pipe_mode ? st_q.ovld : rd_now;
        q      = pipe_mode ? st_q.odat : merged;
        q_oe   = rd_vld && !oe_n && !sleep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: sleep at an edge lets no command into stage 1
    a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !st_q.s1.vld);

    // R7: linear continuation steps the low bits by one, page fixed
    a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !burst_ilv) |->
            ((cmd_addr[BEAT_W-1:0] == BEAT_W'(st_q.s1.addr[BEAT_W-1:0] + 1'b1))
             && (cmd_addr[AW-1:BEAT_W] == st_q.s1.addr[AW-1:BEAT_W])));

    // R8: interleaved continuation stays in the page and moves the low bits
    a_r8_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && burst_ilv) |->
            ((cmd_addr[AW-1:BEAT_W] == st_q.s1.addr[AW-1:BEAT_W])
             && (cmd_addr[BEAT_W-1:0] != st_q.s1.addr[BEAT_W-1:0])));

    // R4: in registered mode a commit follows a write held in stage 1 one edge earlier
    a_r4_pipe_write_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && wen) |-> $past(st_q.s1.vld && st_q.s1.wr));

endmodule

// File: tb/lw_sram_tb_top.sv
`timescale 1ns/1ps
module lw_sram_tb_top;

    localparam int AW = 8;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0, burst_ilv = 1'b0;
    logic          sel0 = 1'b0, sel1 = 1'b0, sel2 = 1'b0;
    logic          adv = 1'b0, we = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [NB-1:0] bwe = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic          q_oe;

    always #4 clk = ~clk;

    lw_sram #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .sel0(sel0), .sel1(sel1), .sel2(sel2), .adv(adv), .we(we), .bwe(bwe),
        .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep), .q(q), .q_oe(q_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    int    n      = 0;
    string tag    = "R12";

    logic [DW-1:0] ref_mem [DEPTH];
    bit            rv [8];
    bit            wv [8];
    logic [AW-1:0] ra [8];
    logic [AW-1:0] wa [8];
    logic [NB-1:0] wb [8];

    bit            b_act = 0, b_wr = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] new_w,
                                                  input logic [NB-1:0] be);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < NB; i++)
            if (be[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
        return r;
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] base,
                                                 input logic [1:0] beat,
                                                 input bit ilv);
        logic [1:0] lo = ilv ? (base[1:0] ^ beat) : (base[1:0] + beat);
        return {base[AW-1:2], lo};
    endfunction

    task automatic chk_bit(input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s q_oe=%0b expected=%0b cycle=%0d", tag, act, exp, n);
        end
    endtask

    task automatic chk_data(input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s q=%h expected=%h cycle=%0d", tag, act, exp, n);
        end
    endtask

    task automatic step(input bit s_ok, input bit a, input bit w,
                        input logic [AW-1:0] ad, input logic [NB-1:0] be,
                        input bit slp, input bit oen);
        int            slot, lat, ns;
        bit            iss, iss_wr, exp_oe;
        logic [AW-1:0] iss_a;
        @(negedge clk);
        slot = n % 8;
        if (s_ok) {sel0, sel1, sel2} = 3'b111;
        else case ($urandom % 3)
            0:       {sel0, sel1, sel2} = 3'b011;
            1:       {sel0, sel1, sel2} = 3'b101;
            default: {sel0, sel1, sel2} = 3'b110;
        endcase
        adv = a; we = w; addr = ad; bwe = be; sleep = slp; oe_n = oen;
        din = DW'($urandom);
        #1;
        exp_oe = rv[slot] && !oen && !slp;
        chk_bit(q_oe, exp_oe);
        if (exp_oe) chk_data(q, ref_mem[ra[slot]]);
        if (wv[slot]) ref_mem[wa[slot]] = merge_bytes(ref_mem[wa[slot]], din, wb[slot]);
        rv[slot] = 0;
        wv[slot] = 0;
        // command model (R1, R7, R8, R9, R11)
        iss = 0; iss_wr = 0; iss_a = ad;
        if (slp) begin
            b_act = 0;
        end else if (a) begin
            if (b_act) begin
                b_cnt  = b_cnt + 2'd1;
                iss    = 1;
                iss_wr = b_wr;
                iss_a  = burst_addr(b_base, b_cnt, burst_ilv);
            end
        end else if (s_ok) begin
            b_act = 1; b_wr = w; b_base = ad; b_cnt = 2'd0;
            iss = 1; iss_wr = w; iss_a = ad;
        end else begin
            b_act = 0;
        end
        lat = pipe_mode ? 2 : 1;
        ns  = (n + lat) % 8;
        if (iss) begin
            if (iss_wr) begin wv[ns] = 1; wa[ns] = iss_a; wb[ns] = be; end
            else        begin rv[ns] = 1; ra[ns] = iss_a; end
        end
        n++;
    endtask

    task automatic idle();
        step(0, 0, 0, '0, '0, 0, 0);
    endtask

    task automatic do_reset(input bit pm);
        @(negedge clk);
        rst_n = 0; pipe_mode = pm;
        {sel0, sel1, sel2} = 3'b000; adv = 0; we = 0; sleep = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rv[i] = 0; wv[i] = 0; end
        n = 0; b_act = 0;
        rst_n = 1;
        #1;
        tag = "R12";
        chk_bit(q_oe, 1'b0);
    endtask

    task automatic rand_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step(($urandom % 100) < 85, ($urandom % 3) == 0, $urandom % 2,
                 AW'($urandom), NB'($urandom), ($urandom % 50) == 0,
                 ($urandom % 30) == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

        do_reset(0);
        tag = "R4";
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, AW'(i), '1, 0, 0);
        idle();

        tag = "R2";
        step(1, 0, 0, 8'h10, '0, 0, 0);
        step(1, 0, 0, 8'h11, '0, 0, 0);
        idle();

        tag = "R5";
        step(1, 0, 1, 8'h20, 2'b01, 0, 0);
        step(1, 0, 0, 8'h20, '0, 0, 0);
        step(1, 0, 1, 8'h21, 2'b10, 0, 0);
        step(1, 0, 0, 8'h21, '0, 0, 0);
        idle(); idle();

        tag = "R1";
        step(0, 0, 0, 8'h40, '0, 0, 0);
        idle(); idle();

        tag = "R10";
        step(1, 0, 0, 8'h30, '0, 0, 0);
        step(0, 0, 0, '0, '0, 0, 1);
        idle();

        tag = "R11";
        step(1, 0, 0, 8'h31, '0, 1, 0);
        idle(); idle();

        tag = "R9";
        idle();
        step(1, 1, 0, 8'h32, '0, 0, 0);
        idle(); idle();

        tag = "R7";
        burst_ilv = 0;
        step(1, 0, 1, 8'h52, 2'b11, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h00, 2'b11, 0, 0);
        step(1, 0, 0, 8'h52, '0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 1, 8'hff, '0, 0, 0);
        idle(); idle();

        tag = "R8";
        burst_ilv = 1;
        idle();
        step(1, 0, 0, 8'h25, '0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 1, 0, 8'h00, '0, 0, 0);
        idle(); idle();

        tag = "R13";
        burst_ilv = 0;
        rand_run(1000);
        burst_ilv = 1;
        idle();
        rand_run(1000);
        idle(); idle(); idle();

        do_reset(1);
        burst_ilv = 0;
        tag = "R3";
        step(1, 0, 0, 8'h10, '0, 0, 0);
        step(1, 0, 0, 8'h11, '0, 0, 0);
        idle(); idle();

        tag = "R6";
        step(1, 0, 1, 8'h60, 2'b11, 0, 0);
        step(1, 0, 0, 8'h60, '0, 0, 0);
        step(1, 0, 1, 8'h61, 2'b10, 0, 0);
        step(1, 0, 0, 8'h61, '0, 0, 0);
        step(1, 0, 1, 8'h62, 2'b01, 0, 0);
        step(1, 0, 0, 8'h62, '0, 0, 0);
        step(1, 0, 0, 8'h62, '0, 0, 0);
        idle(); idle(); idle();

        rand_run(1500);
        burst_ilv = 1;
        idle();
        rand_run(1500);
        idle(); idle(); idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", n);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule